// File: doc/BRIEF.md
# Byte-Lane Read Path over a Word-Wide RAM

This block serves 8-bit reads from a memory stored as 16-bit words. The RAM holds half as many words as there are bytes. A stream of byte addresses arrives with no gaps forced on it, at most one per clock. Each byte address is split in two. The upper bits form the word address that goes to a synchronous RAM with a two-cycle read latency. The least significant bit picks which half of the returned word is wanted.

The RAM output changes on every cycle. For that reason the half-select bit is not taken from the address now at the input. It travels through a delay line that is exactly as long as the RAM read latency. That way it meets the word that its own address produced. A valid flag rides next to it through the same stages.

A host port writes whole words under a per-byte enable, so one byte can be changed without touching its partner.

Top module: `byte_lane_reader`

## Requirements
- R1: The RAM word address is the byte address shifted right by one, and the RAM holds 2^(BYTE_ADDR_W-1) words of 16 bits.
- R2: The byte for an address accepted on clock edge N is presented after edge N+2, that is, two cycles later.
- R3: Byte address bit 0 = 0 returns word bits 7:0, and bit 0 = 1 returns word bits 15:8.
- R4: The half-select applied at the output comes from the same address that fetched the current word, even when even and odd addresses alternate on every cycle.
- R5: A new address is accepted on every cycle with no stall, and every accepted address yields exactly one output byte.
- R6: `rd_valid_o` is high exactly two cycles after a cycle in which `rd_valid_i` was high, and low otherwise.
- R7: `rd_byte_o` is zero whenever `rd_valid_o` is low.
- R8: While `rst_n` is low, the delay-line valid bits are cleared, so `rd_valid_o` is low and `rd_byte_o` is zero.
- R9: A host write updates word bits 7:0 when `wr_byte_en_i[0]` is set and bits 15:8 when `wr_byte_en_i[1]` is set. A byte whose enable is clear keeps its old value.
- R10: A host write with `wr_byte_en_i` = 2'b00 leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | A read address is present this cycle |
| rd_byte_addr_i | input | BYTE_ADDR_W | Byte address to read |
| rd_valid_o | output | 1 | Output byte is valid |
| rd_byte_o | output | 8 | Byte read, two cycles after its address |
| wr_en_i | input | 1 | Host word write strobe |
| wr_word_addr_i | input | BYTE_ADDR_W-1 | Host word address |
| wr_data_i | input | 16 | Host write data |
| wr_byte_en_i | input | 2 | Per-byte write enable; bit 0 covers bits 7:0 |

## Verification
The latency and select assertions assume that a host write never targets a word while a read of that same word is still inside the two-cycle pipeline. Under that condition the returned byte depends only on the address and the memory contents. The bench keeps to this condition by placing host writes in their own phases and inserting idle cycles before any read phase begins. Inside a read phase, reads run back to back, either with random gaps or with none. The latency assertions also assume that `rd_valid_i` counts only after two clean post-reset edges, and the checker tracks those edges itself.

// File: rtl/blr_pkg.sv
package blr_pkg;
  localparam int BYTE_W     = 8;
  localparam int LANES      = 2;
  localparam int WORD_W     = BYTE_W * LANES;
  localparam int RD_LATENCY = 2;

  typedef logic [BYTE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;

  // Half select: 0 -> bits 7:0, 1 -> bits 15:8
  function automatic lane_t pick_lane(input word_t w, input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // Lane-wise merge under byte enables
  function automatic word_t merge_lanes(input word_t old_w, input word_t new_w,
                                        input logic [LANES-1:0] be);
    word_t r;
    r = old_w;
    for (int k = 0; k < LANES; k++)
      if (be[k]) r[k*BYTE_W +: BYTE_W] = new_w[k*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/blr_word_ram.sv
module blr_word_ram
  import blr_pkg::*;
#(
  parameter int WADDR_W = 9
) (
  input  logic               clk,
  input  logic [WADDR_W-1:0] rd_addr,
  output logic [WADDR_W-1:0] rd_addr_q,
  output word_t              rd_data,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  word_t              wr_data,
  input  logic [LANES-1:0]   wr_be
);
  localparam int DEPTH = 1 << WADDR_W;

  word_t mem [DEPTH];

  // Stage 1: address register; stage 2: data register
  always_ff @(posedge clk) begin
    rd_addr_q <= rd_addr;
    rd_data   <= mem[rd_addr_q];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merge_lanes(mem[wr_addr], wr_data, wr_be);
  end
endmodule

// File: rtl/blr_sel_pipe.sv
module blr_sel_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sel,
  output logic out_valid,
  output logic out_sel
);
  logic [STAGES-1:0] v_q;
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      s_q <= '0;
    end else begin
      v_q[0] <= in_valid;
      s_q[0] <= in_sel;
      for (int i = 1; i < STAGES; i++) begin
        v_q[i] <= v_q[i-1];
        s_q[i] <= s_q[i-1];
      end
    end
  end

  assign out_valid = v_q[STAGES-1];
  assign out_sel   = s_q[STAGES-1];
endmodule

// File: rtl/blr_lane_mux.sv
module blr_lane_mux
  import blr_pkg::*;
(
  input  logic  valid,
  input  logic  sel,
  input  word_t word,
  output logic  valid_o,
  output lane_t byte_o
);
  assign valid_o = valid;
  assign byte_o  = valid ? pick_lane(word, sel) : '0;
endmodule

// File: rtl/byte_lane_reader.sv
module byte_lane_reader
  import blr_pkg::*;
#(
  parameter int BYTE_ADDR_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_valid_i,
  input  logic [BYTE_ADDR_W-1:0] rd_byte_addr_i,
  output logic                   rd_valid_o,
  output logic [7:0]             rd_byte_o,
  input  logic                   wr_en_i,
  input  logic [BYTE_ADDR_W-2:0] wr_word_addr_i,
  input  logic [15:0]            wr_data_i,
  input  logic [1:0]             wr_byte_en_i
);
  localparam int WORD_ADDR_W = BYTE_ADDR_W - 1;

  // Named internal events for the checker
  logic [WORD_ADDR_W-1:0] word_addr;
  logic                   lane_sel_in;
  logic [WORD_ADDR_W-1:0] ram_rd_addr_q;
  word_t                  ram_word;
  logic                   mux_sel;
  logic                   mux_valid;

  assign word_addr   = rd_byte_addr_i[BYTE_ADDR_W-1:1];
  assign lane_sel_in = rd_byte_addr_i[0];

  blr_word_ram #(.WADDR_W(WORD_ADDR_W)) u_ram (
    .clk      (clk),
    .rd_addr  (word_addr),
    .rd_addr_q(ram_rd_addr_q),
    .rd_data  (ram_word),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_word_addr_i),
    .wr_data  (wr_data_i),
    .wr_be    (wr_byte_en_i)
  );

  blr_sel_pipe #(.STAGES(RD_LATENCY)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rd_valid_i),
    .in_sel   (lane_sel_in),
    .out_valid(mux_valid),
    .out_sel  (mux_sel)
  );

  blr_lane_mux u_mux (
    .valid  (mux_valid),
    .sel    (mux_sel),
    .word   (ram_word),
    .valid_o(rd_valid_o),
    .byte_o (rd_byte_o)
  );
endmodule

// File: rtl/byte_lane_reader_chk.sv
module byte_lane_reader_chk #(
  parameter int BYTE_ADDR_W = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_valid_i,
  input logic [BYTE_ADDR_W-1:0] rd_byte_addr_i,
  input logic                   rd_valid_o,
  input logic [7:0]             rd_byte_o,
  input logic [BYTE_ADDR_W-2:0] ram_rd_addr_q,
  input logic                   mux_sel
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |-> ram_rd_addr_q == $past(rd_byte_addr_i[BYTE_ADDR_W-1:1])); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> rd_valid_o == $past(rd_valid_i, 2)); // R6
  AST_SEL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2 && rd_valid_o) |-> mux_sel == $past(rd_byte_addr_i[0], 2)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> rd_byte_o == 8'h00); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!rd_valid_o && rd_byte_o == 8'h00)); // R8
endmodule

bind byte_lane_reader byte_lane_reader_chk #(.BYTE_ADDR_W(BYTE_ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_valid_i    (rd_valid_i),
  .rd_byte_addr_i(rd_byte_addr_i),
  .rd_valid_o    (rd_valid_o),
  .rd_byte_o     (rd_byte_o),
  .ram_rd_addr_q (ram_rd_addr_q),
  .mux_sel       (mux_sel)
);

// File: tb/byte_lane_reader_bench.sv
`timescale 1ns/1ps
module byte_lane_reader_bench;
  localparam int AW    = 10;
  localparam int WORDS = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_valid_i = 1'b0;
  logic [AW-1:0] rd_byte_addr_i = '0;
  logic          rd_valid_o;
  logic [7:0]    rd_byte_o;
  logic          wr_en_i = 1'b0;
  logic [AW-2:0] wr_word_addr_i = '0;
  logic [15:0]   wr_data_i = '0;
  logic [1:0]    wr_byte_en_i = '0;

  always #2.5 clk = ~clk;

  byte_lane_reader #(.BYTE_ADDR_W(AW)) u_byte_lane_reader (.*);

  logic [15:0] ref_w [WORDS];
  int n_chk = 0;
  int n_bad = 0;
  logic       pv0 = 1'b0, pv1 = 1'b0;
  logic [7:0] pb0 = '0,   pb1 = '0;
  string      pt0 = "",   pt1 = "";

  function automatic logic [7:0] model_byte(input logic [AW-1:0] a);
    logic [15:0] w;
    w = ref_w[a / 2];
    return (a % 2 == 1) ? 8'(w >> 8) : 8'(w & 16'h00FF);
  endfunction

  function automatic logic [15:0] model_merge(input logic [15:0] o, input logic [15:0] n,
                                              input logic [1:0] be);
    logic [15:0] m;
    m = {(be[1] ? 8'hFF : 8'h00), (be[0] ? 8'hFF : 8'h00)};
    return (n & m) | (o & ~m);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: compare oldest in-flight item, then drive new inputs
  task automatic tick(input logic v, input logic [AW-1:0] a, input string tag,
                      input logic we = 1'b0, input logic [AW-2:0] wa = '0,
                      input logic [15:0] wd = '0, input logic [1:0] be = '0);
    @(negedge clk);
    check(rd_valid_o == pv1, {tag == "" ? "R6" : pt1, " valid"}, int'(rd_valid_o), int'(pv1));
    if (pv1) check(rd_byte_o == pb1, {pt1, " byte"}, int'(rd_byte_o), int'(pb1));
    else     check(rd_byte_o == 8'h00, "R7 idle byte", int'(rd_byte_o), 0);
    pv1 = pv0; pb1 = pb0; pt1 = pt0;
    rd_valid_i = v; rd_byte_addr_i = a;
    pv0 = v; pb0 = v ? model_byte(a) : 8'h00; pt0 = tag;
    wr_en_i = we; wr_word_addr_i = wa; wr_data_i = wd; wr_byte_en_i = be;
    if (we) ref_w[wa] = model_merge(ref_w[wa], wd, be);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) tick(1'b0, '0, "");
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int w = 0; w < WORDS; w++) ref_w[w] = '0;
    // R8: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_valid_i = 1'b1; rd_byte_addr_i = AW'(i);
      check(!rd_valid_o && rd_byte_o == 8'h00, "R8 reset quiet", int'({rd_valid_o, rd_byte_o}), 0);
    end
    rd_valid_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // R9: full-word fill, all words distinct
    for (int w = 0; w < WORDS; w++)
      tick(1'b0, '0, "", 1'b1, (AW-1)'(w), 16'((w * 16'h9E37) ^ 16'h5A5A), 2'b11);
    drain();
    // R1 R3: corners of the address space
    tick(1'b1, 10'd0, "R1 R3 addr0");
    tick(1'b1, 10'd1, "R1 R3 addr1");
    tick(1'b1, 10'd1023, "R1 R3 top odd");
    tick(1'b1, 10'd1022, "R1 R3 top even");
    // R4 R5 R2: gapless alternating even/odd stream
    for (int i = 0; i < 128; i++) tick(1'b1, AW'(i * 7), "R2 R4 R5 stream");
    // R6: gaps in the valid strobe
    for (int i = 0; i < 60; i++) tick(i % 3 != 0, AW'(300 + i), "R6 gaps");
    drain();
    // R9 R10: byte-enable writes
    tick(1'b0, '0, "", 1'b1, 9'd5, 16'hAAAA, 2'b01);
    tick(1'b0, '0, "", 1'b1, 9'd6, 16'hBBBB, 2'b10);
    tick(1'b0, '0, "", 1'b1, 9'd7, 16'hCCCC, 2'b00);
    drain();
    for (int a = 10; a < 16; a++) tick(1'b1, AW'(a), a < 14 ? "R9 lane write" : "R10 no-enable write");
    drain();
    // Random reads
    for (int i = 0; i < 2000; i++)
      tick(($urandom % 4) != 0, AW'($urandom), "R2 R3 R4 random");
    drain();
    // Random partial writes, then reads
    for (int i = 0; i < 64; i++)
      tick(1'b0, '0, "", 1'b1, (AW-1)'($urandom), 16'($urandom), 2'($urandom));
    drain();
    for (int i = 0; i < 1500; i++)
      tick(1'b1, AW'($urandom), "R5 R9 R10 random");
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule